// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a CPU and the program memories of a cartridge-style system. It maps each CPU address from 0x6000 to 0xFFFF onto a physical ROM or RAM location. A 2-bit mode picks how the 0x8000–0xFFFF space is divided: one 32 KB window, two 16 KB windows, a 16 KB and two 8 KB windows, or four 8 KB windows. Five 8-bit bank registers supply the bank numbers. The register for 0x6000–0x7FFF can only point at RAM, and the register for 0xE000–0xFFFF can only point at ROM. Each of the other three registers carries a flag bit that chooses between ROM and RAM.

RAM writes pass only while two small key registers hold one agreed pair of values. RAM is built from one or two 8 KB-bank chips, chosen by the `DUAL_RAM` parameter. A RAM bank that points at a chip that is not fitted reads as open bus. All address outputs are combinational from the current CPU address. A register write changes them from the next clock cycle.

Top module: `pbm_mapper`

## Requirements
- R1: After reset the mode is 3 and the 0xE000 register holds 0xFF. Both key registers and the other four bank registers hold 0. A read at 0xE000–0xFFFF therefore selects ROM bank 0x7F, and a read at 0x8000–0xDFFF selects RAM bank 0.
- R2: The window at 0x6000–0x7FFF is always RAM. Its bank is bits 2:0 of register select 3, whatever bit 7 holds.
- R3: The window whose register is select 7 (it always covers 0xE000–0xFFFF) is always ROM. Its bank is bits 6:0 of that register, and bit 7 has no effect.
- R4: For register selects 4, 5 and 6, bit 7 = 1 selects ROM bank bits 6:0, and bit 7 = 0 selects RAM bank bits 2:0. The ROM physical address is bank×8192 plus the offset in bits 12:0. The RAM physical address is (bank bits 1:0)×8192 plus that offset, and RAM bank bit 2 names the chip.
- R5: In mode 0, 0x8000–0xFFFF is one 32 KB window from select 7. The register's bits 1:0 are replaced by CPU address bits 14:13.
- R6: In mode 1, 0x8000–0xBFFF comes from select 5 and 0xC000–0xFFFF comes from select 7. Both are 16 KB windows, with bank bit 0 replaced by CPU address bit 13.
- R7: In mode 2, 0x8000–0xBFFF is a 16 KB window from select 5, with bit 0 replaced by address bit 13. 0xC000–0xDFFF is an 8 KB window from select 6, and 0xE000–0xFFFF is an 8 KB window from select 7.
- R8: In mode 3, the four 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000 come from selects 4, 5, 6 and 7.
- R9: `ram_we` rises only for a CPU write to a fitted RAM bank while key A bits 1:0 equal 2 and key B bits 1:0 equal 1. Bits 7:2 of the key registers are ignored.
- R10: With `DUAL_RAM`=1, RAM banks 0–3 drive `ram_chip`=0 and banks 4–7 drive `ram_chip`=1. With `DUAL_RAM`=0, banks 4–7 select nothing: a read raises `open_bus` and a write is dropped.
- R11: A CPU write to a ROM window asserts neither `rom_sel` nor `ram_we`. `rom_sel` is raised only for reads.
- R12: Addresses below 0x6000 raise no select, no write enable and no open bus, and `phys_addr` reads 0.
- R13: Register selects are 0 for mode, 1 for key A, 2 for key B, and 3–7 for the bank registers of 0x6000, 0x8000, 0xA000, 0xC000 and 0xE000. A write takes effect from the next cycle. Selects 8–15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_data | input | REG_W | Register write data |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| phys_addr | output | ROM_BANK_W+OFS_W | Physical ROM or RAM address |
| rom_sel | output | 1 | ROM read select |
| ram_sel | output | 1 | RAM access select |
| ram_chip | output | 1 | RAM chip index (valid with ram_sel) |
| ram_we | output | 1 | RAM write enable |
| open_bus | output | 1 | Read of an unfitted RAM bank |

## Verification
The hardest case to reach is a RAM write that lands on a fitted bank while both key registers hold the exact pair. Key B must also carry extra high bits that have to be masked. Reaching it needs a bank register pointed at RAM, two key writes in order, and then a CPU write in a chosen window. The stimulus walks the keys through wrong, partly right and right values, with a write probe after each step. It runs single-chip and dual-chip instances side by side on the same stimulus, so one bank value shows both the open-bus path and the second-chip path. A behavioural model in the bench predicts every output on every cycle, across address sweeps after each mode change.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   localparam int unsigned SLOT_COUNT = 5;
   localparam int unsigned SLOT_W     = 3;

   localparam logic [3:0] SEL_MODE      = 4'd0;
   localparam logic [3:0] SEL_KEY_A     = 4'd1;
   localparam logic [3:0] SEL_KEY_B     = 4'd2;
   localparam logic [3:0] SEL_SLOT_BASE = 4'd3;

   localparam logic [1:0] KEY_A_VAL = 2'd2;
   localparam logic [1:0] KEY_B_VAL = 2'd1;

   localparam logic [SLOT_W-1:0] SLOT_LOW  = 3'd0;  // 0x6000 window, RAM only
   localparam logic [SLOT_W-1:0] SLOT_LAST = 3'd4;  // 0xE000 window, ROM only

   typedef enum logic [1:0] {
      MAP_32K       = 2'd0,
      MAP_16K_16K   = 2'd1,
      MAP_16K_8K_8K = 2'd2,
      MAP_8K_X4     = 2'd3
   } map_mode_e;

   typedef enum logic [1:0] {
      SPAN_8K  = 2'd0,
      SPAN_16K = 2'd1,
      SPAN_32K = 2'd2
   } span_e;

   typedef struct packed {
      logic              hit;
      logic [SLOT_W-1:0] slot;
      span_e             span;
   } window_t;

endpackage

// File: rtl/pbm_regs.sv
module pbm_regs
   import pbm_pkg::*;
#(
   parameter int unsigned      REG_W      = 8,
   parameter logic [REG_W-1:0] LAST_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [3:0]       reg_sel,
   input  logic [REG_W-1:0] reg_data,
   output map_mode_e        mode_o,
   output logic             key_ok_o,
   output logic [REG_W-1:0] bank_o [SLOT_COUNT]
);

   logic [1:0] mode_q;
   logic [1:0] key_a_q;
   logic [1:0] key_b_q;

   if (REG_W < 4) begin : g_bad_reg_w
      $error("pbm_regs: REG_W must be at least 4");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= 2'd3;
         key_a_q <= 2'd0;
         key_b_q <= 2'd0;
      end else if (reg_wr) begin
         case (reg_sel)
            SEL_MODE:  mode_q  <= reg_data[1:0];
            SEL_KEY_A: key_a_q <= reg_data[1:0];
            SEL_KEY_B: key_b_q <= reg_data[1:0];
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_bank
      localparam logic [REG_W-1:0] RST_VAL = (g == SLOT_COUNT - 1) ? LAST_RESET : '0;
      logic [REG_W-1:0] bank_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_q <= RST_VAL;
         end else if (reg_wr && reg_sel == SEL_SLOT_BASE + 4'(g)) begin
            bank_q <= reg_data;
         end
      end
      assign bank_o[g] = bank_q;
   end

   assign mode_o   = map_mode_e'(mode_q);
   assign key_ok_o = (key_a_q == KEY_A_VAL) && (key_b_q == KEY_B_VAL);

   a_r13_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_MODE) |=> (mode_q == $past(reg_data[1:0])));

   a_r9_key_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_KEY_B) |=> (key_b_q == $past(reg_data[1:0])));

endmodule

// File: rtl/pbm_window_decode.sv
module pbm_window_decode
   import pbm_pkg::*;
(
   input  map_mode_e  mode,
   input  logic [2:0] region,
   output window_t    win
);

   always_comb begin
      win.hit  = 1'b0;
      win.slot = SLOT_LOW;
      win.span = SPAN_8K;
      if (region == 3'd3) begin
         win.hit = 1'b1;
      end else if (region > 3'd3) begin
         win.hit = 1'b1;
         unique case (mode)
            MAP_32K: begin
               win.slot = SLOT_LAST;
               win.span = SPAN_32K;
            end
            MAP_16K_16K: begin
               win.slot = region[1] ? SLOT_LAST : 3'd2;
               win.span = SPAN_16K;
            end
            MAP_16K_8K_8K: begin
               if (!region[1]) begin
                  win.slot = 3'd2;
                  win.span = SPAN_16K;
               end else begin
                  win.slot = region[0] ? SLOT_LAST : 3'd3;
               end
            end
            MAP_8K_X4: begin
               win.slot = region - 3'd3;
            end
         endcase
      end
   end

endmodule

// File: rtl/pbm_bank_resolve.sv
module pbm_bank_resolve
   import pbm_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned RAM_BANK_W = 3,
   parameter bit          DUAL_RAM   = 1'b0,
   localparam int unsigned ROM_BANK_W = REG_W - 1
) (
   input  logic [SLOT_W-1:0]     slot,
   input  span_e                 span,
   input  logic [REG_W-1:0]      bank_val,
   input  logic [1:0]            unit,
   output logic                  is_rom,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  ram_chip,
   output logic                  ram_mapped
);

   logic [1:0]            keep_m;
   logic [RAM_BANK_W-1:0] ram_raw;

   if (RAM_BANK_W < 3 || RAM_BANK_W >= REG_W) begin : g_bad_ram_w
      $error("pbm_bank_resolve: RAM_BANK_W must lie in 3..REG_W-1");
   end

   always_comb begin
      case (span)
         SPAN_8K:  keep_m = 2'b00;
         SPAN_16K: keep_m = 2'b01;
         default:  keep_m = 2'b11;
      endcase
   end

   always_comb begin
      if (slot == SLOT_LAST)     is_rom = 1'b1;
      else if (slot == SLOT_LOW) is_rom = 1'b0;
      else                       is_rom = bank_val[REG_W-1];
   end

   assign ram_raw  = bank_val[RAM_BANK_W-1:0];
   assign rom_bank = {bank_val[ROM_BANK_W-1:2], (bank_val[1:0] & ~keep_m) | (unit & keep_m)};
   assign ram_bank = {ram_raw[RAM_BANK_W-1:2], (ram_raw[1:0] & ~keep_m) | (unit & keep_m)};
   assign ram_chip = ram_bank[RAM_BANK_W-1];

   if (DUAL_RAM) begin : g_dual
      assign ram_mapped = 1'b1;
   end else begin : g_single
      assign ram_mapped = ~ram_chip;
   end

endmodule

// File: rtl/pbm_mapper.sv
module pbm_mapper
   import pbm_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned RAM_BANK_W = 3,
   parameter int unsigned OFS_W      = 13,
   parameter int unsigned ADDR_W     = 16,
   parameter bit          DUAL_RAM   = 1'b0,
   localparam int unsigned ROM_BANK_W = REG_W - 1,
   localparam int unsigned PA_W       = ROM_BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_data,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [PA_W-1:0]   phys_addr,
   output logic              rom_sel,
   output logic              ram_sel,
   output logic              ram_chip,
   output logic              ram_we,
   output logic              open_bus
);

   localparam int unsigned RAM_PA_W = RAM_BANK_W - 1 + OFS_W;

   if (ADDR_W != OFS_W + 3) begin : g_bad_addr_w
      $error("pbm_mapper: ADDR_W must equal OFS_W + 3");
   end

   map_mode_e             mode;
   logic                  key_ok;
   logic [REG_W-1:0]      bank_q [SLOT_COUNT];
   window_t               win;
   logic [REG_W-1:0]      bank_val;
   logic                  is_rom;
   logic [ROM_BANK_W-1:0] rom_bank;
   logic [RAM_BANK_W-1:0] ram_bank;
   logic                  chip;
   logic                  ram_mapped;
   logic                  win_ram;

   pbm_regs #(.REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_sel  (reg_sel),
      .reg_data (reg_data),
      .mode_o   (mode),
      .key_ok_o (key_ok),
      .bank_o   (bank_q)
   );

   pbm_window_decode u_decode (
      .mode   (mode),
      .region (cpu_addr[ADDR_W-1 -: 3]),
      .win    (win)
   );

   always_comb begin
      bank_val = '0;
      for (int i = 0; i < SLOT_COUNT; i++) begin
         if (win.slot == SLOT_W'(i)) bank_val = bank_q[i];
      end
   end

   pbm_bank_resolve #(
      .REG_W      (REG_W),
      .RAM_BANK_W (RAM_BANK_W),
      .DUAL_RAM   (DUAL_RAM)
   ) u_resolve (
      .slot       (win.slot),
      .span       (win.span),
      .bank_val   (bank_val),
      .unit       (cpu_addr[OFS_W+1:OFS_W]),
      .is_rom     (is_rom),
      .rom_bank   (rom_bank),
      .ram_bank   (ram_bank),
      .ram_chip   (chip),
      .ram_mapped (ram_mapped)
   );

   always_comb begin
      if (!win.hit)    phys_addr = '0;
      else if (is_rom) phys_addr = {rom_bank, cpu_addr[OFS_W-1:0]};
      else             phys_addr = PA_W'({ram_bank[RAM_BANK_W-2:0], cpu_addr[OFS_W-1:0]});
   end

   assign win_ram  = win.hit & ~is_rom;
   assign ram_we   = win_ram & ram_mapped & cpu_wr & key_ok;
   assign ram_sel  = win_ram & ram_mapped & (cpu_rd | ram_we);
   assign rom_sel  = win.hit & is_rom & cpu_rd;
   assign open_bus = win_ram & ~ram_mapped & cpu_rd;
   assign ram_chip = ram_sel & chip;

   // RAM physical addresses must fit the output
   if (RAM_PA_W > PA_W) begin : g_bad_ram_pa
      $error("pbm_mapper: RAM address wider than physical address port");
   end

   a_r9_we_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (key_ok && cpu_wr));

   a_r11_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_rd) |-> !rom_sel);

   a_r10_open_bus_alone: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus |-> (!ram_sel && !rom_sel && !ram_we));

   a_r12_low_space_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[ADDR_W-1 -: 3] < 3'd3) |-> !(rom_sel || ram_sel || ram_we || open_bus));

   a_r2_low_window_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[ADDR_W-1 -: 3] == 3'd3) |-> !rom_sel);

   a_r3_last_window_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[ADDR_W-1 -: 3] == 3'd7) |-> !(ram_sel || ram_we || open_bus));

endmodule

// File: tb/pbm_mapper_test.sv
module pbm_mapper_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic [7:0]  reg_data = '0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;

   logic [19:0] s_phys, d_phys;
   logic        s_rom, s_ram, s_chip, s_we, s_ob;
   logic        d_rom, d_ram, d_chip, d_we, d_ob;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_mode, m_ka, m_kb;
   int m_bank[5];

   always #(CLK_P/2) clk = ~clk;

   pbm_mapper uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_data(reg_data),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .phys_addr(s_phys), .rom_sel(s_rom), .ram_sel(s_ram), .ram_chip(s_chip),
      .ram_we(s_we), .open_bus(s_ob)
   );

   pbm_mapper #(.DUAL_RAM(1'b1)) uut_dual (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_data(reg_data),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .phys_addr(d_phys), .rom_sel(d_rom), .ram_sel(d_ram), .ram_chip(d_chip),
      .ram_we(d_we), .open_bus(d_ob)
   );

   // Behavioural prediction: flags are {rom_sel, ram_sel, ram_chip, ram_we, open_bus}
   function automatic void predict(input int dual, input int a, input bit rd, input bit wr,
                                   output int ph, output logic [4:0] fl);
      int region, slot, units, idx, v, b, chip;
      bit rom, mapped, key, we, rs;
      ph = 0;
      fl = '0;
      if (a < 'h6000) return;
      region = a >> 13;
      slot = 0;
      units = 1;
      if (region != 3) begin
         case (m_mode)
            0: begin slot = 4; units = 4; end
            1: begin slot = (region >= 6) ? 4 : 2; units = 2; end
            2: begin
               if (region < 6) begin slot = 2; units = 2; end
               else slot = (region == 6) ? 3 : 4;
            end
            default: slot = region - 3;
         endcase
      end
      idx = region & (units - 1);
      v = m_bank[slot];
      if (slot == 4) rom = 1'b1;
      else if (slot == 0) rom = 1'b0;
      else rom = ((v >> 7) & 1) == 1;
      if (rom) begin
         b = ((v & 'h7F) & ~(units - 1)) | idx;
         ph = b * 8192 + (a & 'h1FFF);
         fl[4] = rd;
      end else begin
         b = ((v & 7) & ~(units - 1)) | idx;
         chip = b >> 2;
         ph = (b & 3) * 8192 + (a & 'h1FFF);
         mapped = (dual != 0) || (chip == 0);
         key = (m_ka == 2) && (m_kb == 1);
         we = mapped && wr && key;
         rs = mapped && (rd || we);
         fl[3] = rs;
         fl[2] = rs && (chip == 1);
         fl[1] = we;
         fl[0] = !mapped && rd;
      end
   endfunction

   task automatic compare_one(input string tag, input int dual, input logic [19:0] ph,
                              input logic [4:0] got);
      int eph;
      logic [4:0] efl;
      predict(dual, int'(cpu_addr), cpu_rd, cpu_wr, eph, efl);
      n_chk++;
      if (ph !== 20'(eph) || got !== efl) begin
         n_fail++;
         $display("FAIL %s dual=%0d addr=%h rd=%b wr=%b: actual phys=%h flags=%b, expected phys=%h flags=%b",
                  tag, dual, cpu_addr, cpu_rd, cpu_wr, ph, got, 20'(eph), efl);
      end
   endtask

   task automatic step(input string tag, input bit w, input int sel, input int d,
                       input int a, input bit rd, input bit wr);
      @(negedge clk);
      reg_wr = w;
      reg_sel = 4'(sel);
      reg_data = 8'(d);
      cpu_addr = 16'(a);
      cpu_rd = rd;
      cpu_wr = wr;
      #(CLK_P/4);
      compare_one(tag, 0, s_phys, {s_rom, s_ram, s_chip, s_we, s_ob});
      compare_one(tag, 1, d_phys, {d_rom, d_ram, d_chip, d_we, d_ob});
      @(posedge clk);
      if (rst_n && w) begin
         case (sel)
            0: m_mode = d & 3;
            1: m_ka = d & 3;
            2: m_kb = d & 3;
            3, 4, 5, 6, 7: m_bank[sel-3] = d & 'hFF;
            default: ;
         endcase
      end
   endtask

   task automatic wreg(input string tag, input int sel, input int d);
      step(tag, 1'b1, sel, d, 0, 1'b0, 1'b0);
   endtask

   task automatic sweep(input string tag);
      int probes[8] = '{'h5FFF, 'h6010, 'h8123, 'hA456, 'hC789, 'hDABC, 'hE001, 'hFFFF};
      for (int i = 0; i < 8; i++) step(tag, 1'b0, 0, 0, probes[i], 1'b1, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      finish_run();
   end

   initial begin
      m_mode = 3; m_ka = 0; m_kb = 0;
      m_bank = '{0, 0, 0, 0, 'hFF};

      // R1: reset values, held and then released
      step("R1", 1'b1, 0, 0, 'hE123, 1'b1, 1'b0);
      step("R1", 1'b0, 0, 0, 'h8000, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1");

      // R12: low space idle for reads and writes
      step("R12", 1'b0, 0, 0, 'h5FFF, 1'b1, 1'b0);
      step("R12", 1'b0, 0, 0, 'h4020, 1'b0, 1'b1);

      // R2 / R10: bit 7 ignored in the low window, bank 5 sits on chip 1
      wreg("R2", 3, 'h85);
      sweep("R2");

      // R3: last register with bit 7 clear still ROM
      wreg("R3", 7, 'h12);
      sweep("R3");

      // R4: ROM flag per register
      wreg("R4", 4, 'h83);
      wreg("R4", 5, 'h02);
      sweep("R4");

      // R8: four 8 KB windows
      wreg("R8", 6, 'hA5);
      sweep("R8");

      // R5: one 32 KB window
      wreg("R5", 0, 0);
      wreg("R5", 7, 'h8F);
      sweep("R5");

      // R6: two 16 KB windows
      wreg("R6", 0, 1);
      wreg("R6", 5, 'h87);
      wreg("R6", 7, 'h93);
      sweep("R6");

      // R7: 16 KB + 8 KB + 8 KB
      wreg("R7", 0, 2);
      sweep("R7");

      // R10: 16 KB RAM window on banks 6/7 (chip 1)
      wreg("R10", 5, 'h06);
      sweep("R10");

      // R9: write key sequence on the low window (RAM bank 1, chip 0)
      wreg("R9", 3, 'h01);
      step("R9", 1'b0, 0, 0, 'h6100, 1'b0, 1'b1);
      wreg("R9", 1, 'hFE);
      step("R9", 1'b0, 0, 0, 'h6100, 1'b0, 1'b1);
      wreg("R9", 2, 'h05);
      step("R9", 1'b0, 0, 0, 'h6100, 1'b0, 1'b1);
      wreg("R9", 2, 'h02);
      step("R9", 1'b0, 0, 0, 'h6100, 1'b0, 1'b1);
      wreg("R9", 2, 'h01);
      step("R9", 1'b0, 0, 0, 'h7FFF, 1'b0, 1'b1);

      // R11: writes to ROM windows with the key open
      step("R11", 1'b0, 0, 0, 'hC010, 1'b0, 1'b1);
      step("R11", 1'b0, 0, 0, 'hE010, 1'b0, 1'b1);
      // R10: RAM write to chip 1 lands only on the dual build
      step("R10", 1'b0, 0, 0, 'hA010, 1'b0, 1'b1);
      step("R12", 1'b0, 0, 0, 'h5000, 1'b0, 1'b1);

      // R13: unused selects change nothing; writes land the next cycle
      wreg("R13", 9, 'h00);
      wreg("R13", 15, 'hFF);
      sweep("R13");
      wreg("R13", 0, 3);
      step("R13", 1'b0, 0, 0, 'hC000, 1'b1, 1'b0);
      sweep("R13");

      finish_run();
   end
endmodule